// File: doc/BRIEF.md
# Two-Operand Arithmetic/Logic Opcode Predecoder

This block is a purely combinational predecoder for 16-bit instruction words that belong to the four opcode lines carrying the two-operand add, subtract, bitwise-and and bitwise-or instructions of a classic 32-bit CISC instruction set. It splits the word into its fields and reports several things about the instruction:

- the operation class;
- the operand size;
- whether the result goes back to a data register or out to an effective address;
- the source and destination operands, each as an addressing-mode code plus a register number;
- a valid flag.

Words on those four lines that encode neighbouring instructions are reported as their own operation classes. These are the address-register add and subtract forms, unsigned and signed multiply, unsigned and signed divide, and packed-BCD subtract.

Legality depends on the operand size, on the direction, and on which line the word is on. A word that breaks a legality rule is reported as illegal with a fixed set of blank outputs, so a later pipeline stage needs only the valid flag to raise an illegal-instruction trap. Extension-word fetch, address arithmetic and execution belong to later stages.

Top module: `dyp_predec`

## Requirements
- R1: Bits 15:12 select the line: 8 is OR, 9 is SUB, C (hex) is AND, D (hex) is ADD, and every other line decodes as illegal. Bits 11:9 give Dn, bits 8:6 the opmode, bits 5:3 the EA mode and bits 2:0 the EA register. The operation codes are: 0 illegal, 1 ADD, 2 SUB, 3 AND, 4 OR, 5 ADDA, 6 SUBA, 7 MULU, 8 MULS, 9 DIVU, 10 DIVS, 11 SBCD.
- R2: Opmodes 000, 001 and 010 are the to-register form, with size codes 0 (byte), 1 (word) and 2 (long). In this form to_mem is 0, the source is the EA, and the destination is data register Dn (mode code 0, register = Dn).
- R3: Opmodes 100, 101 and 110 are the to-memory form, with size codes 0, 1 and 2. In this form to_mem is 1, the source is Dn (mode code 0), and the destination is the EA.
- R4: Opmode 011 and opmode 111 decode to neighbouring instructions, and each of them has the EA as source:
  - On ADD and SUB they give ADDA/SUBA, with size 1 for opmode 011 and size 2 for opmode 111, and the destination is address register Dn (mode code 1).
  - On AND they give MULU/MULS, and on OR they give DIVU/DIVS. Each of these has size 1 and data register Dn as destination.
  - In all four cases an undefined EA makes the word illegal.
- R5: On the OR line, the test that bits 8:4 equal 10000 is made before the OR decode, and a word that meets it decodes as SBCD. SBCD has size 0 and to_mem 0. When bit 3 is 0, both operands use mode code 0; when bit 3 is 1, both use mode code 4 (predecrement). The source register comes from bits 2:0 and the destination register from bits 11:9.
- R6: In the to-register form, an address-register-direct source (mode code 1) is valid at word and long sizes and illegal at byte size.
- R7: In the to-memory form, a destination of address register direct (1), PC with displacement (9), PC with index (10) or immediate (11) makes the word illegal.
- R8: In the to-memory form, AND and OR with a data-register-direct destination are illegal. ADD and SUB with that destination remain valid.
- R9: EA mode 111 with a register field of 101, 110 or 111 is undefined, and any form that uses that EA is illegal.
- R10: An illegal word drives the following outputs:

  | Output | Value |
  |---|---|
  | op_class | 0 |
  | valid | 0 |
  | op_size | 3 |
  | to_mem | 0 |
  | src_mode | 15 |
  | dst_mode | 15 |
  | both register outputs | 0 |

  A legal word always has valid set to 1 and op_class set to a nonzero code.
- R11: Mode codes 0 to 6 are the EA mode field itself. Mode 111 maps to 7 plus its register field, so register 0 gives 7 (absolute short), 1 gives 8 (absolute long), 2 gives 9 (PC with displacement), 3 gives 10 (PC with index) and 4 gives 11 (immediate). Code 15 means no operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 16 | Instruction word to decode |
| op_class | output | 4 | Operation code (R1 list) |
| op_size | output | 2 | 0 byte, 1 word, 2 long, 3 none |
| to_mem | output | 1 | 1 when the EA is the destination |
| src_mode | output | 4 | Source addressing-mode code |
| src_reg | output | 3 | Source register number |
| dst_mode | output | 4 | Destination addressing-mode code |
| dst_reg | output | 3 | Destination register number |
| valid | output | 1 | 1 for a legal decode |

## Verification
The block holds no state, so any internal fault shows at the ports in the same cycle as the word that exposes it. A broken field split or mode mapping shows up as a wrong mode code or register number. A misplaced priority between SBCD and OR, or between the neighbour opmodes and the main decode, shows up as a wrong operation class. A missing legality term shows up as a word that is reported valid when it should be illegal, or illegal when it should be valid. Every word on the four lines is compared against an independent model, so a fault is seen on the first word that reaches it.

// File: rtl/dyp_pkg.sv
package dyp_pkg;
  localparam int OPW = 16;

  localparam logic [3:0] LINE_OR  = 4'h8;
  localparam logic [3:0] LINE_SUB = 4'h9;
  localparam logic [3:0] LINE_AND = 4'hC;
  localparam logic [3:0] LINE_ADD = 4'hD;

  localparam logic [3:0] OP_ILLEGAL = 4'd0;
  localparam logic [3:0] OP_ADD     = 4'd1;
  localparam logic [3:0] OP_SUB     = 4'd2;
  localparam logic [3:0] OP_AND     = 4'd3;
  localparam logic [3:0] OP_OR      = 4'd4;
  localparam logic [3:0] OP_ADDA    = 4'd5;
  localparam logic [3:0] OP_SUBA    = 4'd6;
  localparam logic [3:0] OP_MULU    = 4'd7;
  localparam logic [3:0] OP_MULS    = 4'd8;
  localparam logic [3:0] OP_DIVU    = 4'd9;
  localparam logic [3:0] OP_DIVS    = 4'd10;
  localparam logic [3:0] OP_SBCD    = 4'd11;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;
  localparam logic [1:0] SZ_NONE = 2'd3;

  localparam logic [3:0] EA_DREG   = 4'd0;
  localparam logic [3:0] EA_AREG   = 4'd1;
  localparam logic [3:0] EA_PREDEC = 4'd4;
  localparam logic [3:0] EA_PCD    = 4'd9;
  localparam logic [3:0] EA_PCX    = 4'd10;
  localparam logic [3:0] EA_IMM    = 4'd11;
  localparam logic [3:0] EA_NONE   = 4'd15;

  // kind of decode selected by the line and opmode
  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_MAIN = 2'd1;
  localparam logic [1:0] K_ALT  = 2'd2;
  localparam logic [1:0] K_SBCD = 2'd3;

  // mode field + register field -> flat addressing-mode code
  function automatic logic [3:0] ea_combine(input logic [2:0] m, input logic [2:0] r);
    if (m != 3'd7) return {1'b0, m};
    if (r <= 3'd4) return 4'd7 + {1'b0, r};
    return EA_NONE;
  endfunction

  // destination modes accepted by the to-memory form (data reg handled apart)
  function automatic logic mem_dst_ok(input logic [3:0] c);
    return !(c == EA_AREG || c == EA_PCD || c == EA_PCX ||
             c == EA_IMM  || c == EA_NONE);
  endfunction
endpackage

// File: rtl/dyp_fields.sv
module dyp_fields
  import dyp_pkg::*;
(
  input  logic [OPW-1:0] word,
  output logic [3:0]     line,
  output logic [2:0]     opmode,
  output logic [2:0]     dn,
  output logic [2:0]     ea_reg,
  output logic [3:0]     ea_code,
  output logic           sbcd_pat,
  output logic           sbcd_mem
);
  assign line     = word[15:12];
  assign dn       = word[11:9];
  assign opmode   = word[8:6];
  assign ea_reg   = word[2:0];
  assign ea_code  = ea_combine(word[5:3], word[2:0]);
  assign sbcd_pat = (word[8:4] == 5'b10000);
  assign sbcd_mem = word[3];
endmodule

// File: rtl/dyp_classify.sv
module dyp_classify
  import dyp_pkg::*;
(
  input  logic [3:0] line,
  input  logic [2:0] opmode,
  input  logic       sbcd_pat,
  output logic [3:0] op_raw,
  output logic [1:0] size_raw,
  output logic       dir_mem,
  output logic [1:0] kind
);
  logic on_or, on_sub, on_and, on_add, alt_mode;

  assign on_or    = (line == LINE_OR);
  assign on_sub   = (line == LINE_SUB);
  assign on_and   = (line == LINE_AND);
  assign on_add   = (line == LINE_ADD);
  assign alt_mode = (opmode[1:0] == 2'b11);

  always_comb begin
    op_raw   = OP_ILLEGAL;
    size_raw = SZ_NONE;
    dir_mem  = 1'b0;
    kind     = K_NONE;
    if (on_or && sbcd_pat) begin
      op_raw   = OP_SBCD;
      size_raw = SZ_BYTE;
      kind     = K_SBCD;
    end else if (on_or || on_sub || on_and || on_add) begin
      if (alt_mode) begin
        kind = K_ALT;
        if (on_add || on_sub) begin
          op_raw   = on_add ? OP_ADDA : OP_SUBA;
          size_raw = opmode[2] ? SZ_LONG : SZ_WORD;
        end else begin
          size_raw = SZ_WORD;
          if (on_and) op_raw = opmode[2] ? OP_MULS : OP_MULU;
          else        op_raw = opmode[2] ? OP_DIVS : OP_DIVU;
        end
      end else begin
        kind     = K_MAIN;
        size_raw = opmode[1:0];
        dir_mem  = opmode[2];
        if (on_add)      op_raw = OP_ADD;
        else if (on_sub) op_raw = OP_SUB;
        else if (on_and) op_raw = OP_AND;
        else             op_raw = OP_OR;
      end
    end
  end
endmodule

// File: rtl/dyp_legality.sv
module dyp_legality
  import dyp_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [3:0] op_raw,
  input  logic [1:0] size_raw,
  input  logic       dir_mem,
  input  logic [3:0] ea_code,
  output logic       legal,
  output logic       ea_undef,
  output logic       an_byte_src,
  output logic       mem_dst_bad,
  output logic       logic_dn_dst
);
  assign ea_undef     = (ea_code == EA_NONE);
  assign an_byte_src  = !dir_mem && (ea_code == EA_AREG) && (size_raw == SZ_BYTE);
  assign mem_dst_bad  = dir_mem && !mem_dst_ok(ea_code);
  assign logic_dn_dst = dir_mem && (ea_code == EA_DREG) &&
                        (op_raw == OP_AND || op_raw == OP_OR);

  always_comb begin
    case (kind)
      K_SBCD:  legal = 1'b1;
      K_ALT:   legal = !ea_undef;
      K_MAIN:  legal = dir_mem ? !(mem_dst_bad || logic_dn_dst)
                               : !(ea_undef || an_byte_src);
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/dyp_predec.sv
module dyp_predec
  import dyp_pkg::*;
(
  input  logic [15:0] opcode,
  output logic [3:0]  op_class,
  output logic [1:0]  op_size,
  output logic        to_mem,
  output logic [3:0]  src_mode,
  output logic [2:0]  src_reg,
  output logic [3:0]  dst_mode,
  output logic [2:0]  dst_reg,
  output logic        valid
);
  logic [3:0] line;
  logic [2:0] opmode, dn, ea_reg;
  logic [3:0] ea_code;
  logic       sbcd_pat, sbcd_mem;
  logic [3:0] op_raw;
  logic [1:0] size_raw, kind;
  logic       dir_mem, legal;
  // named events for the checker
  logic       ea_undef, an_byte_src, mem_dst_bad, logic_dn_dst;

  dyp_fields u_fields (
    .word(opcode), .line(line), .opmode(opmode), .dn(dn), .ea_reg(ea_reg),
    .ea_code(ea_code), .sbcd_pat(sbcd_pat), .sbcd_mem(sbcd_mem)
  );

  dyp_classify u_class (
    .line(line), .opmode(opmode), .sbcd_pat(sbcd_pat),
    .op_raw(op_raw), .size_raw(size_raw), .dir_mem(dir_mem), .kind(kind)
  );

  dyp_legality u_legal (
    .kind(kind), .op_raw(op_raw), .size_raw(size_raw), .dir_mem(dir_mem),
    .ea_code(ea_code), .legal(legal), .ea_undef(ea_undef),
    .an_byte_src(an_byte_src), .mem_dst_bad(mem_dst_bad),
    .logic_dn_dst(logic_dn_dst)
  );

  always_comb begin
    op_class = OP_ILLEGAL;
    op_size  = SZ_NONE;
    to_mem   = 1'b0;
    src_mode = EA_NONE;
    src_reg  = 3'd0;
    dst_mode = EA_NONE;
    dst_reg  = 3'd0;
    valid    = 1'b0;
    if (legal) begin
      op_class = op_raw;
      op_size  = size_raw;
      to_mem   = dir_mem;
      valid    = 1'b1;
      case (kind)
        K_SBCD: begin
          src_mode = sbcd_mem ? EA_PREDEC : EA_DREG;
          src_reg  = ea_reg;
          dst_mode = sbcd_mem ? EA_PREDEC : EA_DREG;
          dst_reg  = dn;
        end
        K_ALT: begin
          src_mode = ea_code;
          src_reg  = ea_reg;
          dst_mode = (op_raw == OP_ADDA || op_raw == OP_SUBA) ? EA_AREG : EA_DREG;
          dst_reg  = dn;
        end
        default: begin
          if (dir_mem) begin
            src_mode = EA_DREG;
            src_reg  = dn;
            dst_mode = ea_code;
            dst_reg  = ea_reg;
          end else begin
            src_mode = ea_code;
            src_reg  = ea_reg;
            dst_mode = EA_DREG;
            dst_reg  = dn;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dyp_predec_chk.sv
module dyp_predec_chk (
  input logic [15:0] opcode,
  input logic [3:0]  op_class,
  input logic [1:0]  op_size,
  input logic        to_mem,
  input logic [3:0]  src_mode,
  input logic [3:0]  dst_mode,
  input logic        valid,
  input logic        ea_undef
);
  always_comb begin
    if (!$isunknown(opcode)) begin
      // R10: valid goes with a nonzero operation code
      p_valid_nonzero_r10: assert (valid == (op_class != 4'd0))
        else $error("p_valid_nonzero_r10");
      // R10: illegal words carry the blank pattern
      p_illegal_blank_r10: assert (valid || (op_size == 2'd3 && !to_mem &&
                                   src_mode == 4'd15 && dst_mode == 4'd15))
        else $error("p_illegal_blank_r10");
      // R5: packed-BCD pattern wins on the OR line
      p_sbcd_first_r5: assert (!(opcode[15:12] == 4'h8 && opcode[8:4] == 5'b10000) ||
                               (valid && op_class == 4'd11))
        else $error("p_sbcd_first_r5");
      // R7: to-memory destinations are alterable memory or data register
      p_mem_dst_r7: assert (!(valid && to_mem) ||
                            !(dst_mode == 4'd1 || dst_mode == 4'd9 || dst_mode == 4'd10 ||
                              dst_mode == 4'd11 || dst_mode == 4'd15))
        else $error("p_mem_dst_r7");
      // R6: no byte-size address-register source in main ops
      p_byte_areg_r6: assert (!(valid && !to_mem && op_size == 2'd0 &&
                                op_class >= 4'd1 && op_class <= 4'd4) || src_mode != 4'd1)
        else $error("p_byte_areg_r6");
      // R8: AND/OR never write a data register through the EA
      p_logic_dn_r8: assert (!(valid && to_mem && (op_class == 4'd3 || op_class == 4'd4)) ||
                             dst_mode != 4'd0)
        else $error("p_logic_dn_r8");
      // R9: an undefined EA blocks every EA-using decode
      p_undef_ea_r9: assert (!(ea_undef && op_class != 4'd11) || !valid)
        else $error("p_undef_ea_r9");
    end
  end
endmodule

bind dyp_predec dyp_predec_chk u_chk (
  .opcode(opcode), .op_class(op_class), .op_size(op_size), .to_mem(to_mem),
  .src_mode(src_mode), .dst_mode(dst_mode), .valid(valid), .ea_undef(ea_undef)
);

// File: tb/dyp_predec_test.sv
`timescale 1ns/1ps
module dyp_predec_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] opcode = 16'h0000;
  logic [3:0] op_class, src_mode, dst_mode;
  logic [1:0] op_size;
  logic       to_mem, valid;
  logic [2:0] src_reg, dst_reg;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [21:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  dyp_predec uut (
    .opcode(opcode), .op_class(op_class), .op_size(op_size), .to_mem(to_mem),
    .src_mode(src_mode), .src_reg(src_reg), .dst_mode(dst_mode),
    .dst_reg(dst_reg), .valid(valid)
  );

  // behavioural reference: {op,size,to_mem,smode,sreg,dmode,dreg,valid}
  function automatic logic [21:0] ref_dec(input int w);
    int ln, om, m, r, d, ea, op, sz, tm, sm, sr, dm, dr, ok;
    ln = (w >> 12) & 15; om = (w >> 6) & 7; m = (w >> 3) & 7;
    r = w & 7; d = (w >> 9) & 7;
    ea = (m < 7) ? m : ((r < 5) ? 7 + r : 15);
    ok = 0; op = 0; sz = 3; tm = 0; sm = 15; sr = 0; dm = 15; dr = 0;
    if (ln == 8 && ((w >> 4) & 31) == 16) begin
      ok = 1; op = 11; sz = 0; sm = ((w & 8) != 0) ? 4 : 0; dm = sm; sr = r; dr = d;
    end else if (ln == 8 || ln == 9 || ln == 12 || ln == 13) begin
      if (om == 3 || om == 7) begin
        ok = (ea != 15); sm = ea; sr = r; dr = d;
        if (ln == 13 || ln == 9) begin
          op = (ln == 13) ? 5 : 6; dm = 1; sz = (om == 7) ? 2 : 1;
        end else begin
          dm = 0; sz = 1;
          if (ln == 12) op = (om == 7) ? 8 : 7;
          else          op = (om == 7) ? 10 : 9;
        end
      end else begin
        op = (ln == 13) ? 1 : (ln == 9) ? 2 : (ln == 12) ? 3 : 4;
        sz = om & 3; tm = om >> 2;
        if (tm == 0) begin
          sm = ea; sr = r; dm = 0; dr = d;
          ok = (ea != 15) && !(ea == 1 && sz == 0);
        end else begin
          sm = 0; sr = d; dm = ea; dr = r;
          ok = !(ea == 1 || ea == 9 || ea == 10 || ea == 11 || ea == 15) &&
               !(ea == 0 && (ln == 8 || ln == 12));
        end
      end
    end
    if (ok == 0) return {4'd0, 2'd3, 1'b0, 4'd15, 3'd0, 4'd15, 3'd0, 1'b0};
    return {4'(op), 2'(sz), 1'(tm), 4'(sm), 3'(sr), 4'(dm), 3'(dr), 1'b1};
  endfunction

  function automatic string tag_of(input int w);
    logic [21:0] e;
    int om;
    e = ref_dec(w);
    om = (w >> 6) & 7;
    if (!e[0]) return "R10";
    if (e[21:18] == 4'd11) return "R5";
    if (e[21:18] >= 4'd5) return "R4";
    return (om >= 4) ? "R3" : "R2";
  endfunction

  task automatic apply(input logic [15:0] w, input logic [21:0] e, input string tag);
    @(posedge clk);
    #1 opcode = w;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // compare on every falling edge while a result is pending
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [21:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {op_class, op_size, to_mem, src_mode, src_reg, dst_mode, dst_reg, valid};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s opcode=%h actual=%h expected=%h", t, opcode, a, e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: word 0 is on an unused line (R1, R10)
    apply(16'h0000, {4'd0, 2'd3, 1'b0, 4'd15, 3'd0, 4'd15, 3'd0, 1'b0}, "R1");
    // directed corner cases, expected values worked by hand
    apply(16'h4E71, {4'd0, 2'd3, 1'b0, 4'd15, 3'd0, 4'd15, 3'd0, 1'b0}, "R1");
    apply(16'hD240, {4'd1, 2'd1, 1'b0, 4'd0, 3'd0, 4'd0, 3'd1, 1'b1}, "R2");
    apply(16'hD340, {4'd1, 2'd1, 1'b1, 4'd0, 3'd1, 4'd0, 3'd0, 1'b1}, "R8");
    apply(16'hC340, {4'd0, 2'd3, 1'b0, 4'd15, 3'd0, 4'd15, 3'd0, 1'b0}, "R8");
    apply(16'hD048, {4'd1, 2'd1, 1'b0, 4'd1, 3'd0, 4'd0, 3'd0, 1'b1}, "R6");
    apply(16'hD008, {4'd0, 2'd3, 1'b0, 4'd15, 3'd0, 4'd15, 3'd0, 1'b0}, "R6");
    apply(16'hD308, {4'd0, 2'd3, 1'b0, 4'd15, 3'd0, 4'd15, 3'd0, 1'b0}, "R7");
    apply(16'hD13C, {4'd0, 2'd3, 1'b0, 4'd15, 3'd0, 4'd15, 3'd0, 1'b0}, "R7");
    apply(16'h8101, {4'd11, 2'd0, 1'b0, 4'd0, 3'd1, 4'd0, 3'd0, 1'b1}, "R5");
    apply(16'h830A, {4'd11, 2'd0, 1'b0, 4'd4, 3'd2, 4'd4, 3'd1, 1'b1}, "R5");
    apply(16'h80C0, {4'd9, 2'd1, 1'b0, 4'd0, 3'd0, 4'd0, 3'd0, 1'b1}, "R4");
    apply(16'hD1C0, {4'd5, 2'd2, 1'b0, 4'd0, 3'd0, 4'd1, 3'd0, 1'b1}, "R4");
    apply(16'hD03D, {4'd0, 2'd3, 1'b0, 4'd15, 3'd0, 4'd15, 3'd0, 1'b0}, "R9");
    apply(16'hD03C, {4'd1, 2'd0, 1'b0, 4'd11, 3'd4, 4'd0, 3'd0, 1'b1}, "R11");
    apply(16'hD139, {4'd1, 2'd0, 1'b1, 4'd0, 3'd0, 4'd8, 3'd1, 1'b1}, "R11");
    // every word on the four decoded lines
    foreach (exp_q[i]) begin end
    for (int ln = 0; ln < 16; ln++) begin
      if (ln == 8 || ln == 9 || ln == 12 || ln == 13) begin
        for (int lo = 0; lo < 4096; lo++) begin
          int w;
          w = (ln << 12) | lo;
          apply(16'(w), ref_dec(w), tag_of(w));
        end
      end else begin
        for (int lo = 0; lo < 4096; lo += 255) begin
          int w;
          w = (ln << 12) | lo;
          apply(16'(w), ref_dec(w), "R1");
        end
      end
    end
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule